// File: doc/BRIEF.md
# Lockstep Four-Lane SPI Master

This block is an SPI master that talks to four identical slave devices at the same time. All four slaves share one serial clock, one active-low chip-select and one outgoing command line, so every slave sees the same command bits on the same clock edges. Each slave has its own return line. The master samples all four return lines on the same rising clock edge and shifts each into a separate receive register. Because the link is full duplex, the command goes out while the four responses come in, within one frame.

The host asks for a frame with a one-cycle start strobe. It supplies a command word, a bit count and a clock divider setting along with the strobe. The block raises busy for the length of the frame. When the frame is over it pulses done for one cycle, and at that point the four received words are valid. A start that arrives while a frame is running is ignored.

Top module: `par_spi_master`

## Requirements
- R1: Each of the four return lines is sampled on every rising serial-clock edge of a frame, all four on the same edge. Lane k (bits [32k+31:32k] of `rx_o`) shifts in at its least significant end, so after an n-bit frame the first bit received sits at bit n-1 and bits n and above are zero.
- R2: The command leaves on the single `mosi_o` line most significant bit first, beginning with bit n-1 of `cmd_i`. The first bit is present when chip-select falls. Later bits change only on falling serial-clock edges, so `mosi_o` never changes while `sclk_o` is high.
- R3: The frame length n is taken from `nbits_i`. Values below 8 act as 8, values above 32 act as 32, and every frame has exactly n rising serial-clock edges.
- R4: `sclk_o` rests low. Within a frame each high phase and each low phase lasts `div_i`+1 system clock cycles, which gives a serial clock of the system clock divided by 2×(`div_i`+1).
- R5: `cs_n_o` rests high. It falls on the clock edge that accepts a start, and the first rising serial-clock edge follows `div_i`+1 cycles later. It rises `div_i`+1 cycles after the last falling serial-clock edge, and `sclk_o` is never high while `cs_n_o` is high.
- R6: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`. The frame spans (2n+1)×(`div_i`+1) clock cycles from the accepting edge to the done edge.
- R7: A start strobe that arrives while busy is ignored. The running frame keeps its command, length, divider and timing.
- R8: `done_o` is high for exactly one cycle, on the edge where `cs_n_o` rises. The four received words are valid at that point and stay unchanged until the next start is accepted.
- R9: The command, bit count and divider are captured when a start is accepted. Changing these inputs during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe; ignored while busy |
| cmd_i | input | 32 | Command word; the low n bits are sent |
| nbits_i | input | 6 | Frame length in bits (clamped to 8..32) |
| div_i | input | 8 | Half-period of the serial clock, minus one, in system cycles |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| rx_o | output | 128 | Four received words, lane k at bits [32k+31:32k] |
| sclk_o | output | 1 | Shared serial clock (mode 0) |
| cs_n_o | output | 1 | Shared active-low chip-select |
| mosi_o | output | 1 | Shared command line |
| miso_i | input | 4 | Per-slave return lines, bit k from slave k |

## Verification
The hardest situation to reach from the ports is a second start strobe that lands in the middle of a running frame and carries a different command, length and divider. If the block wrongly accepted it, the frame would restart or be cut short. The stimulus raises start several cycles into a 16-bit frame with a divider above zero, with all inputs changed. The bench then checks that the captured command, the four responses, the number of rising edges and the total cycle count still match the first request. The bench's slave models drive each return line on the falling edges, with a different response per slave. This shows that the four lanes are captured in parallel and never mixed.

// File: rtl/par_spi_pkg.sv
// Package: shared types for the lockstep four-lane SPI master.
// Assumes: included first in compile order.
package par_spi_pkg;

    // Frame sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a start strobe
        ST_LEAD  = 2'd1,   // chip-select low, half period before first edge
        ST_RUN   = 2'd2,   // serial clock toggling
        ST_TRAIL = 2'd3    // half period after last edge, then release
    } seq_state_e;

endpackage

// File: rtl/spi_half_tick.sv
// Module: spi_half_tick
// Produces a one-cycle tick every (div_i+1) system cycles while run_i is high.
// Each tick marks one serial-clock half period.
// Assumes: div_i is held stable while run_i is high, and the count restarts
// from zero whenever run_i is low.
module spi_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    // Half-period counter: wraps at div_i, cleared when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || (cnt_q == div_i)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick when the counter reaches the divider value
    assign tick_o = run_i && (cnt_q == div_i);

    // R4
    // with a divider above zero, two ticks never come back to back
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (div_i != '0) && tick_o) |=> !tick_o);

endmodule

// File: rtl/spi_rx_lane.sv
// Module: spi_rx_lane
// One receive lane. It shifts one return line in at the LSB on each sample
// strobe and is cleared when a frame starts.
// Assumes: sample_i and clear_i never occur in the same cycle.
module spi_rx_lane #(
    parameter int MAX_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                sample_i,
    input  logic                miso_i,
    output logic [MAX_BITS-1:0] word_o
);

    logic [MAX_BITS-1:0] shreg_q;

    // Receive shift register: clear on frame start, shift on sample strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (clear_i) begin
            shreg_q <= '0;
        end else if (sample_i) begin
            shreg_q <= {shreg_q[MAX_BITS-2:0], miso_i};
        end
    end

    assign word_o = shreg_q;

    // R1
    // a sampled bit lands at the LSB on the next cycle
    lane_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !clear_i) |=> (word_o[0] == $past(miso_i)));

    // R8
    // without a sample or clear the word holds its value
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_i && !clear_i) |=> $stable(word_o));

endmodule

// File: rtl/spi_seq_ctrl.sv
// Module: spi_seq_ctrl
// Frame sequencer. It accepts a start, latches the settings and drives the
// shared chip-select, serial clock (mode 0) and command line. It tells the
// receive lanes when to clear and when to sample.
// Assumes: tick_i pulses once per half period while busy_o is high.
module spi_seq_ctrl
    import par_spi_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int MIN_BITS = 8,
    parameter int DIV_W    = 8,
    parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] cmd_i,
    input  logic [CNT_W-1:0]    nbits_i,
    input  logic [DIV_W-1:0]    div_i,
    input  logic                tick_i,
    output logic [DIV_W-1:0]    div_q_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                sclk_o,
    output logic                cs_n_o,
    output logic                mosi_o,
    output logic                clear_o,
    output logic                sample_o
);

    localparam logic [CNT_W-1:0] MIN_N = CNT_W'(MIN_BITS);
    localparam logic [CNT_W-1:0] MAX_N = CNT_W'(MAX_BITS);

    seq_state_e          state_q;
    logic                sclk_q;
    logic                cs_n_q;
    logic                done_q;
    logic [MAX_BITS-1:0] tx_q;
    logic [CNT_W-1:0]    nb_q;
    logic [CNT_W-1:0]    bcnt_q;
    logic [DIV_W-1:0]    div_q;
    logic [CNT_W-1:0]    nb_eff;
    logic                accept;

    // Clamp the requested length into the supported range
    always_comb begin
        if (nbits_i < MIN_N) begin
            nb_eff = MIN_N;
        end else if (nbits_i > MAX_N) begin
            nb_eff = MAX_N;
        end else begin
            nb_eff = nbits_i;
        end
    end

    assign accept = start_i && (state_q == ST_IDLE);

    // Phase sequencing, serial clock, chip-select and command shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sclk_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
            tx_q    <= '0;
            nb_q    <= MIN_N;
            bcnt_q  <= '0;
            div_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        tx_q    <= cmd_i << (MAX_N - nb_eff);
                        nb_q    <= nb_eff;
                        div_q   <= div_i;
                        bcnt_q  <= '0;
                        sclk_q  <= 1'b0;
                        cs_n_q  <= 1'b0;
                        state_q <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick_i) begin
                        sclk_q  <= 1'b1;
                        bcnt_q  <= CNT_W'(1);
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tick_i) begin
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                            if (bcnt_q == nb_q) begin
                                state_q <= ST_TRAIL;
                            end else begin
                                tx_q <= {tx_q[MAX_BITS-2:0], 1'b0};
                            end
                        end else begin
                            sclk_q <= 1'b1;
                            bcnt_q <= bcnt_q + 1'b1;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick_i) begin
                        cs_n_q  <= 1'b1;
                        done_q  <= 1'b1;
                        tx_q    <= '0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign sclk_o   = sclk_q;
    assign cs_n_o   = cs_n_q;
    assign mosi_o   = tx_q[MAX_BITS-1];
    assign div_q_o  = div_q;
    assign clear_o  = accept;
    assign sample_o = tick_i && ((state_q == ST_LEAD) ||
                                 ((state_q == ST_RUN) && !sclk_q));

    // R8
    // done never lasts longer than one cycle
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    // serial clock stays low whenever chip-select is released
    cs_idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R2
    // the command line holds steady while the serial clock is high
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(mosi_o));

    // R4
    // the serial clock moves only on a half-period tick
    sclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(sclk_o));

    // R7
    // a start during a frame leaves the latched settings untouched
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(nb_q) && $stable(div_q)));

    // R6
    // chip-select is only asserted while busy
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

endmodule

// File: rtl/par_spi_master.sv
// Module: par_spi_master (top)
// SPI master serving several identical slaves in lockstep. It uses one
// serial clock, one chip-select and one command line for all of them, and
// each slave's return line is captured in a lane of its own.
// Assumes: miso_i is synchronous to the serial clock the block drives.
module par_spi_master #(
    parameter int N_SLAVES = 4,
    parameter int MAX_BITS = 32,
    parameter int MIN_BITS = 8,
    parameter int DIV_W    = 8,
    parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [MAX_BITS-1:0]          cmd_i,
    input  logic [CNT_W-1:0]             nbits_i,
    input  logic [DIV_W-1:0]             div_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic [N_SLAVES*MAX_BITS-1:0] rx_o,
    output logic                         sclk_o,
    output logic                         cs_n_o,
    output logic                         mosi_o,
    input  logic [N_SLAVES-1:0]          miso_i
);

    logic             tick;
    logic             busy;
    logic             clear;
    logic             sample;
    logic [DIV_W-1:0] div_q;

    spi_seq_ctrl #(
        .MAX_BITS (MAX_BITS),
        .MIN_BITS (MIN_BITS),
        .DIV_W    (DIV_W),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cmd_i    (cmd_i),
        .nbits_i  (nbits_i),
        .div_i    (div_i),
        .tick_i   (tick),
        .div_q_o  (div_q),
        .busy_o   (busy),
        .done_o   (done_o),
        .sclk_o   (sclk_o),
        .cs_n_o   (cs_n_o),
        .mosi_o   (mosi_o),
        .clear_o  (clear),
        .sample_o (sample)
    );

    spi_half_tick #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .div_i  (div_q),
        .tick_o (tick)
    );

    // One receive lane per slave, all sharing the same sample strobe
    for (genvar g = 0; g < N_SLAVES; g++) begin : g_lane
        spi_rx_lane #(
            .MAX_BITS (MAX_BITS)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (clear),
            .sample_i (sample),
            .miso_i   (miso_i[g]),
            .word_o   (rx_o[g*MAX_BITS +: MAX_BITS])
        );
    end

    assign busy_o = busy;

    // R8
    // done coincides with the release of chip-select
    done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !busy_o));

endmodule

// File: tb/par_spi_master_test.sv
// Directed bench for par_spi_master: four slave models with distinct
// responses, a monitor that times the serial bus, one task per scenario.
module par_spi_master_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  cmd_i = '0;
    logic [5:0]   nbits_i = 6'd8;
    logic [7:0]   div_i = '0;
    logic         busy_o, done_o, sclk_o, cs_n_o, mosi_o;
    logic [127:0] rx_o;
    logic [3:0]   miso_i = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    par_spi_master uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .nbits_i(nbits_i), .div_i(div_i), .busy_o(busy_o), .done_o(done_o),
        .rx_o(rx_o), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o),
        .miso_i(miso_i)
    );

    // slave responses and monitor state
    logic [31:0] resp [4];
    int          n_cur = 8;
    int          sidx  = 0;
    int          cyc   = 0;
    int          t_csf, t_rise1, t_lastfall, t_csr, t_tog;
    int          rises, done_cyc, bad_half, mosi_bad;
    logic [31:0] mcap;
    logic        p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0;

    // Monitor and slave models, sampled away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (done_o) done_cyc = done_cyc + 1;
        if (p_cs && !cs_n_o) begin
            t_csf = cyc; t_tog = cyc;
            sidx = n_cur - 1;
            for (int k = 0; k < 4; k++) miso_i[k] = resp[k][sidx];
        end
        if (!p_sclk && sclk_o) begin
            if (rises == 0) t_rise1 = cyc;
            else if (cyc - t_tog != div_i_lat + 1) bad_half = bad_half + 1;
            rises = rises + 1;
            mcap = {mcap[30:0], mosi_o};
            t_tog = cyc;
        end
        if (p_sclk && !sclk_o) begin
            if (cyc - t_tog != div_i_lat + 1) bad_half = bad_half + 1;
            t_lastfall = cyc; t_tog = cyc;
            sidx = sidx - 1;
            if (sidx >= 0) for (int k = 0; k < 4; k++) miso_i[k] = resp[k][sidx];
        end
        if (p_sclk && sclk_o && (mosi_o != p_mosi)) mosi_bad = mosi_bad + 1;
        if (!p_cs && cs_n_o) t_csr = cyc;
        p_cs = cs_n_o; p_sclk = sclk_o; p_mosi = mosi_o;
    end

    int div_i_lat = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Run one frame and check every observable property of it
    task automatic run_frame(input logic [31:0] cmd, input int nreq, input int dv,
                             input logic [31:0] r0, input logic [31:0] r1,
                             input logic [31:0] r2, input logic [31:0] r3,
                             input bit interfere);
        int n, k, exp_cyc;
        bit busy_gap;
        logic [63:0] mask;
        logic [127:0] rx_snap;
        n = (nreq < 8) ? 8 : (nreq > 32) ? 32 : nreq;
        mask = (64'd1 << n) - 64'd1;
        exp_cyc = (2 * n + 1) * (dv + 1);
        @(negedge clk);
        resp[0] = r0; resp[1] = r1; resp[2] = r2; resp[3] = r3;
        n_cur = n; div_i_lat = dv;
        rises = 0; mcap = '0; bad_half = 0; mosi_bad = 0; done_cyc = 0;
        cmd_i = cmd; nbits_i = 6'(nreq); div_i = 8'(dv); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 0; busy_gap = 1'b0;
        while (1) begin
            @(negedge clk);
            k++;
            if (interfere && k == 5) begin
                start_i = 1'b1; cmd_i = ~cmd; nbits_i = 6'd8; div_i = 8'd0;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) break;
            if (!busy_o) busy_gap = 1'b1;
            if (k > 20000) break;
        end
        start_i = 1'b0;
        chk("R6", "frame cycles", 64'(k), 64'(exp_cyc));
        chk("R6", "busy gap before done", 64'(busy_gap), 64'd0);
        chk("R6", "busy low at done", 64'(busy_o), 64'd0);
        chk("R8", "cs_n high at done", 64'(cs_n_o), 64'd1);
        for (int s = 0; s < 4; s++)
            chk("R1", $sformatf("lane %0d word", s),
                64'(rx_o[s*32 +: 32]), 64'(resp[s]) & mask);
        rx_snap = rx_o;
        repeat (4) @(negedge clk);
        chk("R2", "command bits on mosi", 64'(mcap), 64'(cmd) & mask);
        chk("R2", "mosi moved while sclk high", 64'(mosi_bad), 64'd0);
        chk("R3", "rising edge count", 64'(rises), 64'(n));
        chk("R4", "bad half periods", 64'(bad_half), 64'd0);
        chk("R4", "sclk rests low", 64'(sclk_o), 64'd0);
        chk("R5", "cs fall to first rise", 64'(t_rise1 - t_csf), 64'(dv + 1));
        chk("R5", "last fall to cs rise", 64'(t_csr - t_lastfall), 64'(dv + 1));
        chk("R8", "done pulse length", 64'(done_cyc), 64'd1);
        chk("R8", "words held after done", 64'(rx_o == rx_snap), 64'd1);
    endtask

    task automatic t_reset();
        chk("R6", "busy after reset", 64'(busy_o), 64'd0);
        chk("R5", "cs_n after reset", 64'(cs_n_o), 64'd1);
        chk("R4", "sclk after reset", 64'(sclk_o), 64'd0);
        chk("R8", "done after reset", 64'(done_o), 64'd0);
        chk("R1", "rx after reset", 64'(rx_o == '0), 64'd1);
    endtask

    task automatic t_byte_fast();
        run_frame(32'h0000_00A5, 8, 0, 32'h3C, 32'hC3, 32'hFF, 32'h00, 1'b0);
    endtask

    task automatic t_full_word();
        run_frame(32'hDEAD_BEEF, 32, 1, 32'h1234_5678, 32'h8000_0001,
                  32'hFFFF_FFFF, 32'hA5A5_A5A5, 1'b0);
    endtask

    task automatic t_odd_length();
        run_frame(32'hFFFF_FABC, 13, 3, 32'h0000_1555, 32'h0000_0AAA,
                  32'hFFFF_F0F0, 32'h0000_0001, 1'b0);
    endtask

    // R3 clamp: below 8 acts as 8, above 32 acts as 32
    task automatic t_clamp();
        run_frame(32'h0000_0081, 3, 0, 32'h7E, 32'h01, 32'h80, 32'h55, 1'b0);
        run_frame(32'h8000_0001, 40, 0, 32'hC000_0003, 32'h0F0F_0F0F,
                  32'h1111_1111, 32'hFEDC_BA98, 1'b0);
    endtask

    // R7 and R9: a second start with other settings mid-frame is ignored
    task automatic t_busy_ignore();
        run_frame(32'h0000_C3A5, 16, 2, 32'h0000_8001, 32'h0000_7FFE,
                  32'h0000_AAAA, 32'h0000_5555, 1'b1);
    endtask

    initial begin
        resp[0] = '0; resp[1] = '0; resp[2] = '0; resp[3] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_fast();
        t_full_word();
        t_odd_length();
        t_clamp();
        t_busy_ignore();
        t_byte_fast();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule